// File: doc/BRIEF.md
# Advanced-Load Address Check Table

This block lets a compiler hoist a load above earlier stores. The load runs early as an advanced load, and its destination register number and address go into a small associative table. Every store that follows is compared at once against all table entries. Any entry whose 8-byte block matches the store address is invalidated. Later, at the load's original place in the program, a check operation names the register. If that register's entry is still present and valid, the check succeeds. If it is not, the check fails and the pipeline runs recovery code.

Each register number holds at most one entry. A new advanced load to a register that already has an entry overwrites that entry. If a load needs a new entry while the table is full, it evicts the entry written longest ago, and a later check of the evicted register fails. A check never changes the table. The check result appears one cycle after the request. Cache access, the register file and the branch to recovery code lie outside the block.

Top module: `adv_load_table`

## Requirements
- R1: After reset the table is empty, `chk_done` is low, and a check of any register reports a miss (`chk_ok` = 0).
- R2: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high, and `chk_ok` is valid in that cycle.
- R3: After an advanced load of register r, a check of r hits. A check leaves the entry in place, so a repeated check also hits.
- R4: A store invalidates an entry when bits [ADDR_W-1:GRAN] of the two addresses are equal. With GRAN=3 this is the same 8-byte block, and a difference in bits [2:0] alone still matches. A store to another block leaves the entry valid.
- R5: One store invalidates every matching entry in the same cycle, and entries in other blocks stay valid.
- R6: An advanced load to a register that already has an entry overwrites its address. A store to the old address then no longer affects it, and a store to the new address does.
- R7: When the table is full and a load needs a new entry, the entry written least recently is replaced. A check of the replaced register then misses, and the other entries still hit.
- R8: Overwriting an entry makes it the most recently written entry for the purpose of replacement.
- R9: An entry freed by a store is reused before any valid entry is replaced. Recency order among the remaining entries is kept.
- R10: When a store and an advanced load occur in the same cycle, the store is applied first. A new entry for the same block therefore survives, while older entries in that block are invalidated.
- R11: A check sees the table as it stood before that cycle's store and load take effect.
- R12: A check of a register that was never loaded, or whose entry was replaced or invalidated, reports a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Advanced-load insert request |
| ld_reg | input | REG_W | Destination register of the advanced load |
| ld_addr | input | ADDR_W | Address of the advanced load |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | ADDR_W | Store address |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register to check |
| chk_done | output | 1 | Check result valid, one cycle after the request |
| chk_ok | output | 1 | 1 = entry present and valid; 0 = recovery needed |

## Verification
The bench builds the table with ENTRIES=4, REG_W=6, ADDR_W=32 and GRAN=3. With only four entries, a few loads fill the table, so replacement of the least recently written entry can be reached quickly. The same setting covers the refresh of recency on overwrite, and reuse of a freed slot followed by a second replacement that depends on the compacted recency order. GRAN=3 lets the bench probe the block-matching boundary with addresses that differ only in their low three bits.

// File: rtl/adv_load_table.sv
module adv_load_table #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 48,
  parameter int GRAN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_done,
  output logic              chk_ok
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = ADDR_W - GRAN;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_n, vld_s, st_hit, ld_hit, chk_vec;
  logic [REG_W-1:0]   reg_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [IDX_W-1:0]   age_s [ENTRIES];
  logic [IDX_W-1:0]   age_n [ENTRIES];
  logic [IDX_W-1:0]   slot;
  logic               fresh;

  wire [TAG_W-1:0] st_tag = st_addr[ADDR_W-1:GRAN];
  wire [TAG_W-1:0] ld_tag = ld_addr[ADDR_W-1:GRAN];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_hit[i]  = st_valid && vld_q[i] && (tag_q[i] == st_tag);
    assign ld_hit[i]  = vld_s[i] && (reg_q[i] == ld_reg);
    assign chk_vec[i] = vld_q[i] && (reg_q[i] == chk_reg);
  end

  assign vld_s = vld_q & ~st_hit;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [IDX_W:0] drop;
      drop = '0;
      for (int j = 0; j < ENTRIES; j++)
        if (st_hit[j] && age_q[j] < age_q[i]) drop = drop + 1'b1;
      age_s[i] = age_q[i] - drop[IDX_W-1:0];
    end
  end

  always_comb begin
    slot  = '0;
    fresh = 1'b0;
    if (|ld_hit) begin
      for (int i = 0; i < ENTRIES; i++)
        if (ld_hit[i]) slot = IDX_W'(i);
    end else if (~&vld_s) begin
      fresh = 1'b1;
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!vld_s[i]) slot = IDX_W'(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (age_s[i] == OLDEST) slot = IDX_W'(i);
    end
  end

  always_comb begin
    vld_n = vld_s;
    for (int i = 0; i < ENTRIES; i++) begin
      age_n[i] = age_s[i];
      if (ld_valid && vld_s[i] && IDX_W'(i) != slot &&
          (fresh || age_s[i] < age_s[slot]))
        age_n[i] = age_s[i] + 1'b1;
    end
    if (ld_valid) begin
      vld_n[slot] = 1'b1;
      age_n[slot] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      chk_done <= 1'b0;
      chk_ok   <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        reg_q[i] <= '0;
        tag_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      vld_q    <= vld_n;
      chk_done <= chk_valid;
      chk_ok   <= chk_valid && (|chk_vec);
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_n[i];
      if (ld_valid) begin
        reg_q[slot] <= ld_reg;
        tag_q[slot] <= ld_tag;
      end
    end
  end

  logic [REG_W-1:0] ld_reg_d;
  logic [TAG_W-1:0] st_tag_d;
  logic [ENTRIES-1:0] pres_d, left_d, old_vec;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_reg_d <= '0;
      st_tag_d <= '0;
    end else begin
      ld_reg_d <= ld_reg;
      st_tag_d <= st_tag;
    end
  end
  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    assign pres_d[i]  = vld_q[i] && (reg_q[i] == ld_reg_d);
    assign left_d[i]  = vld_q[i] && (tag_q[i] == st_tag_d);
    assign old_vec[i] = vld_q[i] && (age_q[i] == OLDEST);
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done); // R2
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done); // R2
  AST_INSERT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (|pres_d)); // R3
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid) |=> !(|left_d)); // R5
  AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_vec)); // R6
  AST_FULL_HAS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_q) |-> $onehot(old_vec)); // R7
endmodule

// File: tb/adv_load_table_tb.sv
module adv_load_table_tb;
  localparam int ENTRIES = 4, REG_W = 6, ADDR_W = 32, GRAN = 3;
  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, st_valid = 0, chk_valid = 0;
  logic [REG_W-1:0] ld_reg = '0, chk_reg = '0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
  logic chk_done, chk_ok;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adv_load_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .GRAN(GRAN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr), .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_done(chk_done), .chk_ok(chk_ok));

  task automatic expect1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    ld_valid = 0; st_valid = 0; chk_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic op(logic lv, logic [REG_W-1:0] lr, logic [ADDR_W-1:0] la,
                    logic sv, logic [ADDR_W-1:0] sa);
    ld_valid = lv; ld_reg = lr; ld_addr = la;
    st_valid = sv; st_addr = sa;
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
  endtask

  task automatic ins(logic [REG_W-1:0] r, logic [ADDR_W-1:0] a);
    op(1, r, a, 0, '0);
  endtask

  task automatic st(logic [ADDR_W-1:0] a);
    op(0, '0, '0, 1, a);
  endtask

  task automatic chk(logic [REG_W-1:0] r, logic exp, string req);
    chk_valid = 1; chk_reg = r;
    @(negedge clk);
    chk_valid = 0;
    expect1(req, "chk_done", chk_done, 1'b1);
    expect1(req, $sformatf("chk_ok reg %0d", r), chk_ok, exp);
  endtask

  function automatic logic [ADDR_W-1:0] ad(int r);
    return ADDR_W'(32'h1000 + r * 32'h40);
  endfunction

  task automatic t_reset();
    do_reset();
    expect1("R1", "chk_done after reset", chk_done, 1'b0);
    chk(5, 0, "R1");
    @(negedge clk);
    expect1("R2", "chk_done drops", chk_done, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    ins(3, ad(3));
    chk(3, 1, "R3");
    chk(3, 1, "R3");
    chk(4, 0, "R12");
  endtask

  task automatic t_gran();
    do_reset();
    ins(7, 32'h2000);
    st(32'h2040);
    chk(7, 1, "R4");
    st(32'h2005);
    chk(7, 0, "R4");
  endtask

  task automatic t_multi();
    do_reset();
    ins(8, 32'h3000);
    ins(9, 32'h3004);
    ins(10, 32'h3100);
    st(32'h3000);
    chk(8, 0, "R5");
    chk(9, 0, "R5");
    chk(10, 1, "R5");
  endtask

  task automatic t_overwrite();
    do_reset();
    ins(11, 32'h4000);
    ins(11, 32'h5000);
    st(32'h4000);
    chk(11, 1, "R6");
    st(32'h5000);
    chk(11, 0, "R6");
  endtask

  task automatic t_full();
    do_reset();
    for (int r = 1; r <= 4; r++) ins(r, ad(r));
    ins(5, ad(5));
    chk(1, 0, "R7");
    for (int r = 2; r <= 5; r++) chk(r, 1, "R7");
  endtask

  task automatic t_refresh();
    do_reset();
    for (int r = 1; r <= 4; r++) ins(r, ad(r));
    ins(1, ad(9));
    ins(5, ad(5));
    chk(1, 1, "R8");
    chk(2, 0, "R8");
    chk(3, 1, "R8");
  endtask

  task automatic t_reuse();
    do_reset();
    for (int r = 1; r <= 4; r++) ins(r, ad(r));
    st(ad(2));
    ins(5, ad(5));
    chk(1, 1, "R9");
    chk(2, 0, "R9");
    chk(4, 1, "R9");
    chk(5, 1, "R9");
    ins(6, ad(6));
    chk(1, 0, "R9");
    chk(3, 1, "R9");
    chk(6, 1, "R9");
  endtask

  task automatic t_same_cycle();
    do_reset();
    ins(13, 32'h6000);
    op(1, 12, 32'h6000, 1, 32'h6000);
    chk(12, 1, "R10");
    chk(13, 0, "R10");
  endtask

  task automatic t_check_order();
    do_reset();
    ins(14, 32'h7000);
    chk_valid = 1; chk_reg = 14;
    st_valid = 1; st_addr = 32'h7000;
    @(negedge clk);
    chk_valid = 0; st_valid = 0;
    expect1("R11", "chk_ok sees prior state", chk_ok, 1'b1);
    chk(14, 0, "R11");
    chk_valid = 1; chk_reg = 15;
    ld_valid = 1; ld_reg = 15; ld_addr = 32'h7100;
    @(negedge clk);
    chk_valid = 0; ld_valid = 0;
    expect1("R11", "chk_ok before insert", chk_ok, 1'b0);
    chk(15, 1, "R11");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gran();
    t_multi();
    t_overwrite();
    t_full();
    t_refresh();
    t_reuse();
    t_same_cycle();
    t_check_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule